// File: doc/BRIEF.md
# JTAG Instruction Load and Core-Clock Sequencer

This block is a JTAG master engine. It drives TCK, TMS and TDI to load an instruction register of a configured length (1 to 16 bits), and it then makes a requested number of passes through Run-Test/Idle. Each pass gives one clock pulse to a core under debug. A request carries three items: the instruction value, a flag that picks which end of the instruction is shifted first, and a core-clock count. The TAP is expected to be in Select-DR-Scan when a request starts, and the engine returns it to Select-DR-Scan when the request finishes.

TCK comes from the system clock through a programmable divider. TMS and TDI change together with the falling edge of TCK, so the target samples them on the rising edge. Each request ends with a one-cycle `done` pulse and an error code. A code of 0 means success, 1 means the count was out of range, and 2 means the TAP state is not trusted. The state stops being trusted when an external TAP reset is reported, and stays that way until that reset is acknowledged.

Top module: `jtag_irclk_seq`

## Requirements
- R1: After reset, `busy`, `done`, `tck` and `err` are all 0.
- R2: An accepted request raises `busy` in the cycle after acceptance. `busy` stays high until the finishing edge, where `busy` falls and `done` is high for exactly one cycle with `err` = 0. `busy` and `done` are never high together.
- R3: While busy, every TCK low half and every TCK high half lasts `div_ratio`+1 system cycles. TMS and TDI change only at the edge where TCK goes low, or at the start of a request.
- R4: The IR part of the TMS stream is 1, 0, 0, then one bit per instruction bit (0 for each bit except the last, which is 1), then 1.
- R5: With `req_msb_first` = 0, instruction bit 0 goes out on TDI first. With `req_msb_first` = 1, bit IR_LEN-1 goes out first. TDI is 0 on every step that is not a shift step.
- R6: With a count of 0, the step after the IR part uses TMS 1. This goes from Update-IR straight to Select-DR-Scan and skips Run-Test/Idle.
- R7: With a count N of 1 or more, the step after the IR part uses TMS 0. The engine then runs N-1 passes of the pattern 1, 0, 1, 1, 0. Together with the final step this gives N exits from Run-Test/Idle.
- R8: The last step of every request drives TMS 1, so the TAP finishes in Select-DR-Scan.
- R9: A count above 31 is rejected. `done` pulses one cycle after the request with `err` = 1, `busy` stays low and TCK does not toggle.
- R10: After a pulse on `tap_reset_evt`, every request is rejected with `err` = 2 until a pulse on `tap_reset_ack`. This error takes priority over the count check.
- R11: A request made while `busy` is high is ignored. The TCK, TMS and TDI stream of the run in progress is unchanged.
- R12: `div_ratio` is captured when a request is accepted. Changing it during a run does not change that run's TCK timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| div_ratio | input | DIV_W | TCK half-period minus one, in system cycles |
| req_valid | input | 1 | Request strobe |
| req_instr | input | 16 | Instruction value; the low IR_LEN bits are used |
| req_msb_first | input | 1 | 0: bit 0 shifted first; 1: bit IR_LEN-1 shifted first |
| req_nclk | input | CNT_W | Requested number of core clocks |
| tap_reset_evt | input | 1 | Pulse: an external TAP reset has happened |
| tap_reset_ack | input | 1 | Pulse: the external TAP reset is acknowledged |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 2 | Result code, valid with `done` (0 ok, 1 bad count, 2 bad TAP state) |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data to the target |

## Verification
A wrong phase, index or pass counter in the step planner shows up as a TMS value that differs from the expected stream within one TCK period of the fault. The same fault also shows up at `done`: the shadow TAP state is no longer Select-DR-Scan, or the count of Run-Test/Idle exits does not match the request. A wrong bit pick shows up on TDI during the shift steps. A divider fault moves a TCK edge by at least one system cycle. A stuck trust flag turns the next good request into an error pulse, or a rejected one into a full run.

// File: rtl/jirs_pkg.sv
package jirs_pkg;

  localparam int unsigned IDX_W = 5;

  typedef enum logic [2:0] {
    PH_HEAD, PH_SHIFT, PH_UPD, PH_LEAVE, PH_PASS, PH_FINAL
  } phase_e;

  typedef enum logic [3:0] {
    TS_TLR, TS_RTI, TS_SELDR, TS_CAPDR, TS_SHDR, TS_EX1DR, TS_PAUDR, TS_EX2DR,
    TS_UPDR, TS_SELIR, TS_CAPIR, TS_SHIR, TS_EX1IR, TS_PAUIR, TS_EX2IR, TS_UPIR
  } tap_e;

  localparam logic [1:0] ERR_NONE  = 2'd0;
  localparam logic [1:0] ERR_COUNT = 2'd1;
  localparam logic [1:0] ERR_STATE = 2'd2;

  // TMS of one Run-Test/Idle pass, step 0 first: 1,0,1,1,0
  localparam logic [4:0] PASS_TMS = 5'b01101;

  function automatic logic pick_bit(input logic [15:0] v, input logic msb,
                                    input logic [IDX_W-1:0] idx,
                                    input logic [IDX_W-1:0] len);
    logic [IDX_W-1:0] pos;
    pos = msb ? (len - 5'd1 - idx) : idx;
    return v[pos[3:0]];
  endfunction

  function automatic logic step_tms(input phase_e ph, input logic [IDX_W-1:0] idx,
                                    input logic no_clk, input logic last_bit);
    case (ph)
      PH_HEAD:  return (idx == '0);
      PH_SHIFT: return last_bit;
      PH_LEAVE: return no_clk;
      PH_PASS:  return PASS_TMS[idx[2:0]];
      default:  return 1'b1;
    endcase
  endfunction

  function automatic tap_e tap_next(input tap_e s, input logic m);
    case (s)
      TS_TLR:   return m ? TS_TLR   : TS_RTI;
      TS_RTI:   return m ? TS_SELDR : TS_RTI;
      TS_SELDR: return m ? TS_SELIR : TS_CAPDR;
      TS_CAPDR: return m ? TS_EX1DR : TS_SHDR;
      TS_SHDR:  return m ? TS_EX1DR : TS_SHDR;
      TS_EX1DR: return m ? TS_UPDR  : TS_PAUDR;
      TS_PAUDR: return m ? TS_EX2DR : TS_PAUDR;
      TS_EX2DR: return m ? TS_UPDR  : TS_SHDR;
      TS_UPDR:  return m ? TS_SELDR : TS_RTI;
      TS_SELIR: return m ? TS_TLR   : TS_CAPIR;
      TS_CAPIR: return m ? TS_EX1IR : TS_SHIR;
      TS_SHIR:  return m ? TS_EX1IR : TS_SHIR;
      TS_EX1IR: return m ? TS_UPIR  : TS_PAUIR;
      TS_PAUIR: return m ? TS_EX2IR : TS_PAUIR;
      TS_EX2IR: return m ? TS_UPIR  : TS_SHIR;
      default:  return m ? TS_SELDR : TS_RTI;
    endcase
  endfunction

endpackage

// File: rtl/jirs_tck_div.sv
module jirs_tck_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_lim,
  output logic             tck,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic [DIV_W-1:0] hcnt;
  logic             half_end;

  assign half_end = run && (hcnt == div_lim);
  assign rise_ev  = half_end && !tck;
  assign fall_ev  = half_end && tck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      tck  <= 1'b0;
    end else if (!run) begin
      hcnt <= '0;
      tck  <= 1'b0;
    end else if (half_end) begin
      hcnt <= '0;
      tck  <= !tck;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  // R3
  tck_half_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !half_end) |=> (hcnt != '0));
endmodule

// File: rtl/jirs_step_plan.sv
module jirs_step_plan
  import jirs_pkg::*;
#(
  parameter int unsigned IR_LEN = 4,
  parameter int unsigned RW     = 5
) (
  input  phase_e           ph,
  input  logic [IDX_W-1:0] idx,
  input  logic [RW-1:0]    rem,
  input  logic [RW-1:0]    nclk,
  input  logic [15:0]      instr,
  input  logic             msb_first,
  output phase_e           nph,
  output logic [IDX_W-1:0] nidx,
  output logic [RW-1:0]    nrem,
  output logic             last,
  output logic             ntms,
  output logic             ntdi
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(IR_LEN - 1);
  localparam logic [IDX_W-1:0] LEN_V    = IDX_W'(IR_LEN);

  always_comb begin
    nph  = ph;
    nidx = idx + 1'b1;
    nrem = rem;
    last = 1'b0;
    case (ph)
      PH_HEAD:  if (idx == 5'd2) begin nph = PH_SHIFT; nidx = '0; end
      PH_SHIFT: if (idx == LAST_IDX) begin nph = PH_UPD; nidx = '0; end
      PH_UPD:   begin nph = PH_LEAVE; nidx = '0; end
      PH_LEAVE: begin
        nidx = '0;
        if (nclk == '0)      last = 1'b1;
        else if (nclk == 1)  nph = PH_FINAL;
        else begin nph = PH_PASS; nrem = nclk - 1'b1; end
      end
      PH_PASS:  if (idx == 5'd4) begin
        nidx = '0;
        if (rem == 1) nph = PH_FINAL;
        else          nrem = rem - 1'b1;
      end
      default:  begin last = 1'b1; nidx = '0; end
    endcase
    ntms = step_tms(nph, nidx, nclk == '0, nidx == LAST_IDX);
    ntdi = (nph == PH_SHIFT) ? pick_bit(instr, msb_first, nidx, LEN_V) : 1'b0;
  end
endmodule

// File: rtl/jirs_tap_track.sv
module jirs_tap_track
  import jirs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rise_ev,
  input  logic       tms,
  output tap_e       tap_st,
  output logic [5:0] rti_exits
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_st    <= TS_SELDR;
      rti_exits <= '0;
    end else begin
      if (start) rti_exits <= '0;
      else if (rise_ev && tap_st == TS_RTI && tms) rti_exits <= rti_exits + 1'b1;
      if (rise_ev) tap_st <= tap_next(tap_st, tms);
    end
  end
endmodule

// File: rtl/jtag_irclk_seq.sv
module jtag_irclk_seq
  import jirs_pkg::*;
#(
  parameter int unsigned IR_LEN  = 4,
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned CLK_MAX = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_ratio,
  input  logic             req_valid,
  input  logic [15:0]      req_instr,
  input  logic             req_msb_first,
  input  logic [CNT_W-1:0] req_nclk,
  input  logic             tap_reset_evt,
  input  logic             tap_reset_ack,
  output logic             busy,
  output logic             done,
  output logic [1:0]       err,
  output logic             tck,
  output logic             tms,
  output logic             tdi
);
  localparam int unsigned RW = $clog2(CLK_MAX + 1);

  phase_e           ph, nph;
  logic [IDX_W-1:0] idx, nidx;
  logic [RW-1:0]    rem, nrem, nclk_q;
  logic [15:0]      instr_q;
  logic             msb_q, tap_bad;
  logic [DIV_W-1:0] div_q;
  logic             last, ntms, ntdi;
  logic             rise_ev, fall_ev;
  tap_e             tap_st;
  logic [5:0]       rti_exits;

  // named events
  logic accept, count_bad, start_run, step_adv, run_end;
  logic [1:0] rej_code;
  assign accept    = req_valid && !busy;
  assign count_bad = req_nclk > CNT_W'(CLK_MAX);
  assign rej_code  = tap_bad ? ERR_STATE : (count_bad ? ERR_COUNT : ERR_NONE);
  assign start_run = accept && (rej_code == ERR_NONE);
  assign step_adv  = busy && fall_ev;
  assign run_end   = step_adv && last;

  jirs_tck_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .div_lim(div_q),
    .tck(tck), .rise_ev(rise_ev), .fall_ev(fall_ev));

  jirs_step_plan #(.IR_LEN(IR_LEN), .RW(RW)) u_plan (
    .ph(ph), .idx(idx), .rem(rem), .nclk(nclk_q), .instr(instr_q),
    .msb_first(msb_q), .nph(nph), .nidx(nidx), .nrem(nrem), .last(last),
    .ntms(ntms), .ntdi(ntdi));

  jirs_tap_track u_track (
    .clk(clk), .rst_n(rst_n), .start(start_run), .rise_ev(rise_ev),
    .tms(tms), .tap_st(tap_st), .rti_exits(rti_exits));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap_bad <= 1'b0;
    else if (tap_reset_evt) tap_bad <= 1'b1;
    else if (tap_reset_ack) tap_bad <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; err <= ERR_NONE;
      ph <= PH_HEAD; idx <= '0; rem <= '0; nclk_q <= '0;
      instr_q <= '0; msb_q <= 1'b0; div_q <= '0;
      tms <= 1'b1; tdi <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= ERR_NONE;
      if (accept && rej_code != ERR_NONE) begin
        done <= 1'b1;
        err  <= rej_code;
      end else if (start_run) begin
        busy    <= 1'b1;
        ph      <= PH_HEAD;
        idx     <= '0;
        rem     <= '0;
        nclk_q  <= RW'(req_nclk);
        instr_q <= req_instr;
        msb_q   <= req_msb_first;
        div_q   <= div_ratio;
        tms     <= 1'b1;
        tdi     <= 1'b0;
      end else if (run_end) begin
        busy <= 1'b0;
        done <= 1'b1;
        tdi  <= 1'b0;
      end else if (step_adv) begin
        ph  <= nph;
        idx <= nidx;
        rem <= nrem;
        tms <= ntms;
        tdi <= ntdi;
      end
    end
  end

  // R1
  tck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck);
  // R3
  pins_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tck |-> ($stable(tms) && $stable(tdi)));
  // R2
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  // R8
  end_in_seldr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err == ERR_NONE) |-> (tap_st == TS_SELDR));
  // R7
  exit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err == ERR_NONE) |-> (rti_exits == 6'(nclk_q)));
  // R9
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err != ERR_NONE) |-> !$past(busy));
  // R10
  state_err_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && tap_bad) |=> (done && err == ERR_STATE));
endmodule

// File: tb/jtag_irclk_seq_tb.sv
module jtag_irclk_seq_tb;
  localparam int L = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] div_ratio = '0;
  logic req_valid = 1'b0, req_msb_first = 1'b0;
  logic [15:0] req_instr = '0;
  logic [7:0] req_nclk = '0;
  logic tap_reset_evt = 1'b0, tap_reset_ack = 1'b0;
  logic busy, done, tck, tms, tdi;
  logic [1:0] err;

  always #4 clk = ~clk;

  jtag_irclk_seq #(.IR_LEN(L)) u_dut (
    .clk(clk), .rst_n(rst_n), .div_ratio(div_ratio), .req_valid(req_valid),
    .req_instr(req_instr), .req_msb_first(req_msb_first), .req_nclk(req_nclk),
    .tap_reset_evt(tap_reset_evt), .tap_reset_ack(tap_reset_ack),
    .busy(busy), .done(done), .err(err), .tck(tck), .tms(tms), .tdi(tdi));

  typedef struct packed {
    logic tck, tms, tdi, busy, done;
    logic [1:0] err;
    logic [3:0] ttag, ctag, dtag;
  } rec_t;

  rec_t exp_q[$];
  int checks = 0, fails = 0;
  bit started = 0, model_bad = 0;

  function automatic string tg(input int t);
    case (t)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11"; default: return "R12";
    endcase
  endfunction

  task automatic cmp(input logic a, input logic e, input int t, input string what);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tg(t), what, a, e, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      rec_t r;
      if (exp_q.size() != 0) r = exp_q.pop_front();
      else r = '{tck:0, tms:1, tdi:0, busy:0, done:0, err:0,
                 ttag:4, ctag:4'(started ? 2 : 1), dtag:4'(started ? 2 : 1)};
      cmp(busy, r.busy, r.dtag, "busy");
      cmp(done, r.done, r.dtag, "done");
      cmp(err[0], r.err[0], r.dtag, "err[0]");
      cmp(err[1], r.err[1], r.dtag, "err[1]");
      cmp(tck, r.tck, r.ctag, "tck");
      if (r.busy) begin
        cmp(tms, r.tms, r.ttag, "tms");
        cmp(tdi, r.tdi, 5, "tdi");
      end
    end
  end

  task automatic wait_idle();
    @(posedge clk);
    while (exp_q.size() != 0) @(posedge clk);
    #1;
  endtask

  task automatic push_step(input int h, input logic m, input logic d,
                           input int tt, input int ct);
    for (int k = 0; k < 2 * h; k++)
      exp_q.push_back('{tck:(k >= h), tms:m, tdi:d, busy:1, done:0, err:0,
                        ttag:4'(tt), ctag:4'(ct), dtag:4'd2});
  endtask

  // Issue a request; the model predicts every cycle from it.
  task automatic request(input logic [15:0] ins, input logic msb, input int n,
                         input int dv, input int ctag);
    int h;
    wait_idle();
    started = 1;
    req_valid = 1; req_instr = ins; req_msb_first = msb;
    req_nclk = 8'(n); div_ratio = 8'(dv);
    exp_q.push_back('{tck:0, tms:1, tdi:0, busy:0, done:0, err:0,
                      ttag:4, ctag:2, dtag:2});
    if (model_bad || n > 31) begin
      exp_q.push_back('{tck:0, tms:1, tdi:0, busy:0, done:1,
                        err:(model_bad ? 2'd2 : 2'd1), ttag:4,
                        ctag:4'(model_bad ? 10 : 9), dtag:4'(model_bad ? 10 : 9)});
    end else begin
      h = dv + 1;
      push_step(h, 1, 0, 4, ctag);
      push_step(h, 0, 0, 4, ctag);
      push_step(h, 0, 0, 4, ctag);
      for (int i = 0; i < L; i++)
        push_step(h, i == L - 1, msb ? ins[L - 1 - i] : ins[i], 4, ctag);
      push_step(h, 1, 0, 4, ctag);
      if (n == 0) push_step(h, 1, 0, 6, ctag);
      else begin
        push_step(h, 0, 0, 7, ctag);
        for (int p = 1; p < n; p++) begin
          push_step(h, 1, 0, 7, ctag); push_step(h, 0, 0, 7, ctag);
          push_step(h, 1, 0, 7, ctag); push_step(h, 1, 0, 7, ctag);
          push_step(h, 0, 0, 7, ctag);
        end
        push_step(h, 1, 0, 8, ctag);
      end
      exp_q.push_back('{tck:0, tms:1, tdi:0, busy:0, done:1, err:0,
                        ttag:4, ctag:2, dtag:2});
    end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R2 watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    cmp(busy, 0, 1, "busy after reset"); cmp(tck, 0, 1, "tck after reset");
    cmp(done, 0, 1, "done after reset");
    repeat (3) @(posedge clk);
    request(16'h0004, 0, 1, 0, 3);       // R4 R5 R7 one core clock
    request(16'h000B, 1, 0, 1, 3);       // R5 msb first, R6 no idle
    request(16'h0009, 1, 3, 2, 3);       // R7 three passes
    request(16'h0006, 0, 31, 0, 3);      // R7 boundary count 31
    request(16'h000F, 0, 32, 0, 3);      // R9 first bad count
    request(16'h000F, 0, 200, 0, 3);     // R9
    request(16'h0003, 0, 2, 1, 12);      // R11 and R12 run
    repeat (6) @(posedge clk);
    #1 req_valid = 1; req_instr = 16'h0000; req_nclk = 8'd0; div_ratio = 8'd5;
    @(posedge clk); #1 req_valid = 0;    // R11 ignored while busy, R12 div change
    request(16'h0005, 1, 0, 0, 3);
    wait_idle();
    tap_reset_evt = 1; model_bad = 1;
    @(posedge clk); #1 tap_reset_evt = 0;
    request(16'h0001, 0, 1, 0, 3);       // R10
    request(16'h0001, 0, 40, 0, 3);      // R10 priority over count
    wait_idle();
    tap_reset_ack = 1;
    @(posedge clk); #1 tap_reset_ack = 0; model_bad = 0;
    request(16'h000A, 0, 2, 0, 3);       // R10 cleared by ack
    wait_idle();
    repeat (4) @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule